// File: doc/BRIEF.md
# Capability Seal and Unseal Unit

This unit carries out the two operations that lock and unlock a capability under a type. A caller presents a source capability, a type-authority capability and a one-bit operation select, and raises `reqValid` for one cycle. On the following cycle the unit presents one of two outcomes. The first is the transformed capability, with `resOk` high. The second is a single exception, with `excValid` high, a cause code and a flag naming the operand at fault. Register reads, exception vectoring and memory traffic belong to the surrounding pipeline.

The authority's cursor is the sum of its base and its offset. This sum is formed one bit wider than an address, so it never wraps. Sealing copies the source, marks it sealed and stamps it with the low 24 bits of that cursor. Unsealing accepts only a cursor equal to the type already stamped on the source. It then returns the source unsealed, with its type field zeroed. Every check is evaluated in a fixed priority order, and only the first failing check is reported.

Top module: `capseal_unit`

## Requirements
- R1: A request sampled with `reqValid` high at a rising edge produces exactly one of `resOk` or `excValid` high during the next cycle. A cycle that follows an edge with `reqValid` low has both of them low.
- R2: For a seal (`opUnseal`=0), the checks are taken in this order, and the first failing one is reported: source untagged gives cause 1 on the source; authority untagged gives cause 1 on the authority; source already sealed gives cause 2 on the source; authority sealed gives cause 2 on the authority; authority lacking seal permission gives cause 4 on the authority; authority offset greater than or equal to its length gives cause 5 on the authority; cursor above 2^24-1 gives cause 5 on the authority.
- R3: A successful seal returns the source's tag, permission, base, offset and length unchanged. It sets sealed, and its object type equals the low 24 bits of the cursor.
- R4: For an unseal (`opUnseal`=1), the checks are taken in this order: source untagged (1, source); authority untagged (1, authority); source not sealed (2, source); authority sealed (2, authority); cursor not equal to the zero-extended source object type (3, authority); authority lacking seal permission (4, authority); authority offset greater than or equal to its length (5, authority).
- R5: A successful unseal returns the source's other fields unchanged, with sealed cleared and the object type equal to 0.
- R6: The cursor is computed without wrap-around. A base plus offset that exceeds 64 bits counts as above the type limit when sealing, and as unequal to any stored type when unsealing.
- R7: While `excValid` is high, every result capability output is 0 and `excCause` is non-zero. `excBlameAuth` is 1 when the authority caused the exception and 0 when the source did. While `resOk` is high, `excCause` is 0.
- R8: After reset, `resOk` and `excValid` are low, `excCause` is 0 and all result capability outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per operation |
| opUnseal | input | 1 | 0 = seal, 1 = unseal |
| srcTag | input | 1 | Source validity tag |
| srcSealed | input | 1 | Source sealed flag |
| srcPermSeal | input | 1 | Source seal permission (copied through) |
| srcOtype | input | 24 | Source object type |
| srcBase | input | 64 | Source base |
| srcOffset | input | 64 | Source offset |
| srcLength | input | 64 | Source length |
| authTag | input | 1 | Authority validity tag |
| authSealed | input | 1 | Authority sealed flag |
| authPermSeal | input | 1 | Authority seal permission |
| authBase | input | 64 | Authority base |
| authOffset | input | 64 | Authority offset |
| authLength | input | 64 | Authority length |
| resOk | output | 1 | Result capability valid this cycle |
| excValid | output | 1 | Exception reported this cycle |
| excCause | output | 3 | 0 none, 1 tag, 2 seal state, 3 type, 4 permission, 5 length |
| excBlameAuth | output | 1 | 1 = authority at fault, 0 = source |
| resTag | output | 1 | Result tag |
| resSealed | output | 1 | Result sealed flag |
| resPermSeal | output | 1 | Result seal permission |
| resOtype | output | 24 | Result object type |
| resBase | output | 64 | Result base |
| resOffset | output | 64 | Result offset |
| resLength | output | 64 | Result length |

## Verification
The assertions run on every cycle and cover four properties: the one-outcome-per-request rule, the zeroed capability that accompanies an exception, the sealed flag and type written by each successful operation, and the position of the tag and type checks at the head of the priority chain. Only the bench's scenarios can show the full priority order when several checks fail at once. The same holds for the exact boundaries: offset equal to length, a cursor of exactly 2^24-1 against 2^24, and a base plus offset that carries out of 64 bits. For these, the bench plants a failure at each position of each chain and compares every output field against its own model.

// File: rtl/capseal_pkg.sv
package capseal_pkg;
  localparam int ADDR_W  = 64;
  localparam int OTYPE_W = 24;
  localparam int CAUSE_W = 3;
  localparam int CUR_W   = ADDR_W + 1;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_TAG  = 3'd1,
    CAUSE_SEAL = 3'd2,
    CAUSE_TYPE = 3'd3,
    CAUSE_PERM = 3'd4,
    CAUSE_LEN  = 3'd5
  } causeT;

  typedef enum logic [1:0] {
    OT_KEEP   = 2'd0,
    OT_CURSOR = 2'd1,
    OT_ZERO   = 2'd2
  } otypeSelT;

  typedef struct packed {
    logic     req;
    logic     fail;
    causeT    cause;
    logic     blameAuth;
    logic     setSealed;
    otypeSelT otypeSel;
  } strobeT;
endpackage

// File: rtl/capseal_ctrl.sv
module capseal_ctrl
  import capseal_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   opUnseal,
  input  logic   srcTag,
  input  logic   srcSealed,
  input  logic   authTag,
  input  logic   authSealed,
  input  logic   authPermSeal,
  input  logic   offGeLen,
  input  logic   cursorAboveMax,
  input  logic   cursorNeType,
  output strobeT st
);

  always_comb begin
    st           = '0;
    st.req       = reqValid;
    st.cause     = CAUSE_NONE;
    st.setSealed = !opUnseal;
    st.otypeSel  = opUnseal ? OT_ZERO : OT_CURSOR;
    if (!srcTag) begin
      st.fail = 1'b1; st.cause = CAUSE_TAG; st.blameAuth = 1'b0;
    end else if (!authTag) begin
      st.fail = 1'b1; st.cause = CAUSE_TAG; st.blameAuth = 1'b1;
    end else if (opUnseal ? !srcSealed : srcSealed) begin
      st.fail = 1'b1; st.cause = CAUSE_SEAL; st.blameAuth = 1'b0;
    end else if (authSealed) begin
      st.fail = 1'b1; st.cause = CAUSE_SEAL; st.blameAuth = 1'b1;
    end else if (opUnseal) begin
      if (cursorNeType) begin
        st.fail = 1'b1; st.cause = CAUSE_TYPE; st.blameAuth = 1'b1;
      end else if (!authPermSeal) begin
        st.fail = 1'b1; st.cause = CAUSE_PERM; st.blameAuth = 1'b1;
      end else if (offGeLen) begin
        st.fail = 1'b1; st.cause = CAUSE_LEN; st.blameAuth = 1'b1;
      end
    end else begin
      if (!authPermSeal) begin
        st.fail = 1'b1; st.cause = CAUSE_PERM; st.blameAuth = 1'b1;
      end else if (offGeLen || cursorAboveMax) begin
        st.fail = 1'b1; st.cause = CAUSE_LEN; st.blameAuth = 1'b1;
      end
    end
  end

  // R2 / R4: an untagged source outranks every other check
  a_r2_src_tag_first: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !srcTag) |-> (st.fail && st.cause == CAUSE_TAG && !st.blameAuth));

  // R4: type mismatch outranks permission and length on unseal
  a_r4_type_before_perm: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opUnseal && srcTag && authTag && srcSealed && !authSealed && cursorNeType)
      |-> (st.cause == CAUSE_TYPE && st.blameAuth));

  // R6: a cursor beyond the type range never seals
  a_r6_no_seal_out_of_range: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !opUnseal && cursorAboveMax) |-> st.fail);

endmodule

// File: rtl/capseal_dp.sv
module capseal_dp
  import capseal_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             st,
  input  logic               srcTag,
  input  logic               srcSealed,
  input  logic               srcPermSeal,
  input  logic [OTYPE_W-1:0] srcOtype,
  input  logic [ADDR_W-1:0]  srcBase,
  input  logic [ADDR_W-1:0]  srcOffset,
  input  logic [ADDR_W-1:0]  srcLength,
  input  logic [ADDR_W-1:0]  authBase,
  input  logic [ADDR_W-1:0]  authOffset,
  input  logic [ADDR_W-1:0]  authLength,
  output logic               offGeLen,
  output logic               cursorAboveMax,
  output logic               cursorNeType,
  output logic               resOk,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause,
  output logic               excBlameAuth,
  output logic               resTag,
  output logic               resSealed,
  output logic               resPermSeal,
  output logic [OTYPE_W-1:0] resOtype,
  output logic [ADDR_W-1:0]  resBase,
  output logic [ADDR_W-1:0]  resOffset,
  output logic [ADDR_W-1:0]  resLength
);

  localparam int HI_W = CUR_W - OTYPE_W;

  logic [CUR_W-1:0]   cursor;
  logic [OTYPE_W-1:0] nextOtype;
  causeT              causeQ;

  assign cursor         = {1'b0, authBase} + {1'b0, authOffset};
  assign cursorAboveMax = |cursor[CUR_W-1:OTYPE_W];
  assign offGeLen       = authOffset >= authLength;
  assign cursorNeType   = cursor != {{HI_W{1'b0}}, srcOtype};

  always_comb begin
    unique case (st.otypeSel)
      OT_CURSOR: nextOtype = cursor[OTYPE_W-1:0];
      OT_ZERO:   nextOtype = '0;
      default:   nextOtype = srcOtype;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resOk        <= 1'b0;
      excValid     <= 1'b0;
      causeQ       <= CAUSE_NONE;
      excBlameAuth <= 1'b0;
      resTag       <= 1'b0;
      resSealed    <= 1'b0;
      resPermSeal  <= 1'b0;
      resOtype     <= '0;
      resBase      <= '0;
      resOffset    <= '0;
      resLength    <= '0;
    end else begin
      resOk    <= st.req && !st.fail;
      excValid <= st.req && st.fail;
      if (st.req) begin
        if (st.fail) begin
          causeQ       <= st.cause;
          excBlameAuth <= st.blameAuth;
          resTag       <= 1'b0;
          resSealed    <= 1'b0;
          resPermSeal  <= 1'b0;
          resOtype     <= '0;
          resBase      <= '0;
          resOffset    <= '0;
          resLength    <= '0;
        end else begin
          causeQ       <= CAUSE_NONE;
          excBlameAuth <= 1'b0;
          resTag       <= srcTag;
          resSealed    <= st.setSealed;
          resPermSeal  <= srcPermSeal;
          resOtype     <= nextOtype;
          resBase      <= srcBase;
          resOffset    <= srcOffset;
          resLength    <= srcLength;
        end
      end
    end
  end

  assign excCause = causeQ;

  // R1: one outcome per request, none without a request
  a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    st.req |=> (resOk != excValid));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !st.req |=> (!resOk && !excValid));

  // R7: exception carries a zero capability and a real cause
  a_r7_exc_zero_cap: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (!resTag && !resSealed && !resPermSeal && resOtype == '0 &&
                  resBase == '0 && resOffset == '0 && resLength == '0 &&
                  excCause != CAUSE_NONE));
  a_r7_ok_no_cause: assert property (@(posedge clk) disable iff (!rstN)
    resOk |-> (excCause == CAUSE_NONE));

  // R3: seal stamps the cursor type and sets sealed
  a_r3_seal_stamp: assert property (@(posedge clk) disable iff (!rstN)
    (st.req && !st.fail && st.otypeSel == OT_CURSOR)
      |=> (resSealed && resOtype == $past(cursor[OTYPE_W-1:0])));

  // R5: unseal clears sealed flag and type
  a_r5_unseal_clear: assert property (@(posedge clk) disable iff (!rstN)
    (st.req && !st.fail && st.otypeSel == OT_ZERO)
      |=> (!resSealed && resOtype == '0));

endmodule

// File: rtl/capseal_unit.sv
module capseal_unit
  import capseal_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               opUnseal,
  input  logic               srcTag,
  input  logic               srcSealed,
  input  logic               srcPermSeal,
  input  logic [OTYPE_W-1:0] srcOtype,
  input  logic [ADDR_W-1:0]  srcBase,
  input  logic [ADDR_W-1:0]  srcOffset,
  input  logic [ADDR_W-1:0]  srcLength,
  input  logic               authTag,
  input  logic               authSealed,
  input  logic               authPermSeal,
  input  logic [ADDR_W-1:0]  authBase,
  input  logic [ADDR_W-1:0]  authOffset,
  input  logic [ADDR_W-1:0]  authLength,
  output logic               resOk,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause,
  output logic               excBlameAuth,
  output logic               resTag,
  output logic               resSealed,
  output logic               resPermSeal,
  output logic [OTYPE_W-1:0] resOtype,
  output logic [ADDR_W-1:0]  resBase,
  output logic [ADDR_W-1:0]  resOffset,
  output logic [ADDR_W-1:0]  resLength
);

  strobeT st;
  logic   offGeLen;
  logic   cursorAboveMax;
  logic   cursorNeType;

  capseal_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opUnseal(opUnseal),
    .srcTag(srcTag), .srcSealed(srcSealed), .authTag(authTag),
    .authSealed(authSealed), .authPermSeal(authPermSeal),
    .offGeLen(offGeLen), .cursorAboveMax(cursorAboveMax),
    .cursorNeType(cursorNeType), .st(st)
  );

  capseal_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .srcTag(srcTag), .srcSealed(srcSealed), .srcPermSeal(srcPermSeal),
    .srcOtype(srcOtype), .srcBase(srcBase), .srcOffset(srcOffset),
    .srcLength(srcLength), .authBase(authBase), .authOffset(authOffset),
    .authLength(authLength), .offGeLen(offGeLen),
    .cursorAboveMax(cursorAboveMax), .cursorNeType(cursorNeType),
    .resOk(resOk), .excValid(excValid), .excCause(excCause),
    .excBlameAuth(excBlameAuth), .resTag(resTag), .resSealed(resSealed),
    .resPermSeal(resPermSeal), .resOtype(resOtype), .resBase(resBase),
    .resOffset(resOffset), .resLength(resLength)
  );

endmodule

// File: tb/sim_capseal_unit.sv
`timescale 1ns/1ps
module sim_capseal_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, opUnseal = 1'b0;
  logic srcTag = 1'b0, srcSealed = 1'b0, srcPermSeal = 1'b0;
  logic [23:0] srcOtype = '0;
  logic [63:0] srcBase = '0, srcOffset = '0, srcLength = '0;
  logic authTag = 1'b0, authSealed = 1'b0, authPermSeal = 1'b0;
  logic [63:0] authBase = '0, authOffset = '0, authLength = '0;
  logic resOk, excValid, excBlameAuth, resTag, resSealed, resPermSeal;
  logic [2:0] excCause;
  logic [23:0] resOtype;
  logic [63:0] resBase, resOffset, resLength;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  capseal_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opUnseal(opUnseal),
    .srcTag(srcTag), .srcSealed(srcSealed), .srcPermSeal(srcPermSeal),
    .srcOtype(srcOtype), .srcBase(srcBase), .srcOffset(srcOffset),
    .srcLength(srcLength), .authTag(authTag), .authSealed(authSealed),
    .authPermSeal(authPermSeal), .authBase(authBase), .authOffset(authOffset),
    .authLength(authLength), .resOk(resOk), .excValid(excValid),
    .excCause(excCause), .excBlameAuth(excBlameAuth), .resTag(resTag),
    .resSealed(resSealed), .resPermSeal(resPermSeal), .resOtype(resOtype),
    .resBase(resBase), .resOffset(resOffset), .resLength(resLength)
  );

  // packed view: ok, exc, cause, blame, tag, sealed, perm, otype, base, offset, length
  function automatic logic [224:0] actualVec();
    return {resOk, excValid, excCause, excBlameAuth, resTag, resSealed,
            resPermSeal, resOtype, resBase, resOffset, resLength};
  endfunction

  // reference model written from the requirement list
  function automatic logic [224:0] modelVec(output string tag);
    logic [64:0] cur;
    logic [2:0] cause;
    logic blame;
    cur = {1'b0, authBase} + {1'b0, authOffset};
    cause = 3'd0; blame = 1'b0;
    if (!srcTag) begin cause = 3'd1; blame = 1'b0; end
    else if (!authTag) begin cause = 3'd1; blame = 1'b1; end
    else if (!opUnseal && srcSealed) begin cause = 3'd2; blame = 1'b0; end
    else if (opUnseal && !srcSealed) begin cause = 3'd2; blame = 1'b0; end
    else if (authSealed) begin cause = 3'd2; blame = 1'b1; end
    else if (!opUnseal) begin
      if (!authPermSeal) begin cause = 3'd4; blame = 1'b1; end
      else if (authOffset >= authLength) begin cause = 3'd5; blame = 1'b1; end
      else if (cur > 65'h0FF_FFFF) begin cause = 3'd5; blame = 1'b1; end
    end else begin
      if (cur != {41'd0, srcOtype}) begin cause = 3'd3; blame = 1'b1; end
      else if (!authPermSeal) begin cause = 3'd4; blame = 1'b1; end
      else if (authOffset >= authLength) begin cause = 3'd5; blame = 1'b1; end
    end
    if (cause != 3'd0) begin
      tag = opUnseal ? "R4/R7" : "R2/R7";
      return {1'b0, 1'b1, cause, blame, 1'b0, 1'b0, 1'b0, 24'd0, 64'd0, 64'd0, 64'd0};
    end
    tag = opUnseal ? "R5" : "R3";
    return {1'b1, 1'b0, 3'd0, 1'b0, srcTag, !opUnseal, srcPermSeal,
            opUnseal ? 24'd0 : cur[23:0], srcBase, srcOffset, srcLength};
  endfunction

  task automatic check(input string tag, input logic [224:0] got, input logic [224:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive at negedge, result sampled at the next negedge (one register)
  task automatic runReq(input string extra);
    string tag;
    logic [224:0] exp;
    reqValid = 1'b1;
    exp = modelVec(tag);
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, extra}, actualVec(), exp);
    check({"R1", extra}, {31'd0, resOk ^ excValid}, 32'd1);
  endtask

  task automatic goodSeal();
    opUnseal = 1'b0;
    srcTag = 1; srcSealed = 0; srcPermSeal = 1; srcOtype = 24'h0;
    srcBase = 64'h1000; srcOffset = 64'h8; srcLength = 64'h100;
    authTag = 1; authSealed = 0; authPermSeal = 1;
    authBase = 64'h100; authOffset = 64'h5; authLength = 64'h10;
  endtask

  task automatic goodUnseal();
    goodSeal();
    opUnseal = 1'b1; srcSealed = 1; srcOtype = 24'h105;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", actualVec(), 225'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle cycle after reset stays quiet
    check("R1 idle", {223'd0, resOk, excValid}, 225'd0);

    // R3 / R5 basic successes
    goodSeal();   runReq(" seal ok");
    goodUnseal(); runReq(" unseal ok");

    // R2: each seal check, with later checks also failing to prove priority
    goodSeal(); srcTag = 0; authTag = 0; runReq(" R2 src tag");
    goodSeal(); authTag = 0; srcSealed = 1; runReq(" R2 auth tag");
    goodSeal(); srcSealed = 1; authSealed = 1; runReq(" R2 src sealed");
    goodSeal(); authSealed = 1; authPermSeal = 0; runReq(" R2 auth sealed");
    goodSeal(); authPermSeal = 0; authOffset = 64'h20; runReq(" R2 perm");
    goodSeal(); authOffset = 64'h10; runReq(" R2 off==len");
    goodSeal(); authOffset = 64'hF; runReq(" R2 off=len-1 ok");
    goodSeal(); authBase = 64'hFF_FFF0; authOffset = 64'hF; authLength = 64'h20;
    runReq(" R2 cursor at max ok");
    goodSeal(); authBase = 64'hFF_FFF0; authOffset = 64'h10; authLength = 64'h20;
    runReq(" R2 cursor over max");

    // R4: each unseal check in order
    goodUnseal(); srcTag = 0; authTag = 0; runReq(" R4 src tag");
    goodUnseal(); authTag = 0; srcSealed = 0; runReq(" R4 auth tag");
    goodUnseal(); srcSealed = 0; authSealed = 1; runReq(" R4 src unsealed");
    goodUnseal(); authSealed = 1; srcOtype = 24'h7; runReq(" R4 auth sealed");
    goodUnseal(); srcOtype = 24'h104; authPermSeal = 0; runReq(" R4 type");
    goodUnseal(); authPermSeal = 0; authOffset = 64'h10; srcOtype = 24'h110;
    runReq(" R4 perm");
    goodUnseal(); authOffset = 64'h10; srcOtype = 24'h110; runReq(" R4 off==len");

    // R6: cursor carries out of 64 bits
    goodSeal(); authBase = 64'hFFFF_FFFF_FFFF_FFF0; authOffset = 64'h20;
    authLength = 64'h40; runReq(" R6 seal carry");
    goodUnseal(); authBase = 64'hFFFF_FFFF_FFFF_FFF0; authOffset = 64'h20;
    authLength = 64'h40; srcOtype = 24'h10; runReq(" R6 unseal carry");

    // R1: idle after activity
    @(negedge clk);
    check("R1 idle after req", {223'd0, resOk, excValid}, 225'd0);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      opUnseal     = $urandom_range(1, 0) == 1;
      srcTag       = ($urandom % 8) != 0;
      authTag      = ($urandom % 8) != 0;
      srcSealed    = opUnseal ? (($urandom % 6) != 0) : (($urandom % 6) == 0);
      authSealed   = ($urandom % 8) == 0;
      authPermSeal = ($urandom % 8) != 0;
      srcPermSeal  = $urandom_range(1, 0) == 1;
      srcBase      = {$urandom, $urandom};
      srcOffset    = {$urandom, $urandom};
      srcLength    = {$urandom, $urandom};
      authBase     = ($urandom % 10 == 0) ? {$urandom | 32'h8000_0000, $urandom}
                                          : 64'($urandom % 32'h0100_0000);
      authOffset   = 64'($urandom % 64);
      authLength   = 64'($urandom % 72);
      if ($urandom % 3 != 0) srcOtype = 24'(authBase + authOffset);
      else srcOtype = 24'($urandom);
      runReq(" rand");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule